// File: doc/BRIEF.md
# Partial Timestamp Extender

This block turns a short hardware timestamp into a full 64-bit time value. The short value carries only the low N bits of a free-running tick counter, taken when an event was captured. The current 64-bit counter value arrives with it, and the block supplies the upper bits from that live count. If the live low bits have already passed over the short value, the counter has wrapped since the capture, and one wrap period of 2^N ticks is taken off the result. At the nominal tick rate, a 24-bit short stamp wraps after roughly 0.135 s and a 32-bit one after roughly 34.35 s. The caller must present the live count within one wrap period of the capture. The block does not check that limit.

The mode pin selects N for each beat: 24 bits when it is low, 32 bits when it is high. Beats enter and leave on valid/ready streams, with a single register stage between them. The input side accepts a beat when `in_valid` and `in_ready` are both high in the same cycle. The mode and the live count are taken in that same cycle. `in_ready` is high whenever the output register is empty or is being drained in that cycle.

The output side offers a result while `out_valid` is high. The result stays unchanged until `out_ready` takes it. While a result is held, the input side applies back-pressure.

Top module: `tstamp_extend`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `mode_wide`=0 (N=24), when the low 24 bits of `cnt_now` are greater than the short value, the result is `cnt_now` with its low 24 bits replaced by the short value.
- R3: With `mode_wide`=0, when the low 24 bits of `cnt_now` are less than the short value, the result is the spliced value minus 2^24.
- R4: When the low N bits of `cnt_now` are equal to the short value, 2^N is subtracted from the spliced value. This holds in both modes.
- R5: With `mode_wide`=1 (N=32), the result is `cnt_now` with its low 32 bits replaced by `in_part`. If the live low 32 bits are less than or equal to `in_part`, 2^32 is subtracted.
- R6: With `mode_wide`=0, bits 31:24 of `in_part` have no effect on the result.
- R7: `out_valid` rises in the cycle after an accepted beat. It falls after the result has been taken, unless a new beat is accepted in the same cycle.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1, `out_ts` stays constant, and `in_ready` is 0.
- R9: `in_ready` is 1 whenever `out_ready` is 1. A new beat accepted in a cycle where the held result is taken becomes the next output.
- R10: `mode_wide` matters only in the cycle a beat is accepted. Changing it while a result is held does not alter that result.
- R11: The subtraction wraps modulo 2^64. Example: N=24, `cnt_now`=0x10 and short value 0x20 give 0xFFFFFFFFFF000020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | Short stamp width for the beat: 0 selects 24 bits, 1 selects 32 bits |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_part | input | 32 | Short timestamp; only the low N bits are used |
| cnt_now | input | 64 | Live free-running counter value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_ts | output | 64 | Reconstructed 64-bit timestamp |

## Verification
The main function is driven with vectors in which the live low bits are above, below and exactly equal to the short value, in both widths. These separate the splice-only path from the wrap path, and they also catch a strict-less-than compare in place of less-or-equal. One 24-bit vector sets stray upper bits in the short value, which exposes a missing mask. Another has a zero upper count, so the wrap borrows through all 64 bits. A stalled-output sequence changes the mode and offers a second beat while a result is held, which shows whether holding, back-pressure and the per-beat mode latch behave correctly.

// File: rtl/tstamp_extend_pkg.sv
package tstamp_extend_pkg;
  localparam int unsigned TIME_W   = 64;
  localparam int unsigned SHORT_W  = 24;
  localparam int unsigned LONG_W   = 32;

  typedef struct packed {
    logic [TIME_W-1:0] keep_mask;
    logic [TIME_W-1:0] wrap_step;
  } width_sel_t;
endpackage

// File: rtl/tstamp_mask_gen.sv
module tstamp_mask_gen #(
  parameter int unsigned TIME_W  = 64,
  parameter int unsigned SHORT_W = 24,
  parameter int unsigned LONG_W  = 32
) (
  input  logic              mode_wide,
  output logic [TIME_W-1:0] low_mask,
  output logic [TIME_W-1:0] span
);
  localparam int unsigned SEL_SHORT = SHORT_W;
  localparam int unsigned SEL_LONG  = LONG_W;

  for (genvar b = 0; b < TIME_W; b++) begin : g_bit
    if (b < SEL_SHORT) begin : g_always
      assign low_mask[b] = 1'b1;
    end else if (b < SEL_LONG) begin : g_wide_only
      assign low_mask[b] = mode_wide;
    end else begin : g_never
      assign low_mask[b] = 1'b0;
    end
  end

  assign span = low_mask + {{(TIME_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/tstamp_splice.sv
module tstamp_splice #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned PART_W = 32
) (
  input  logic [PART_W-1:0] part,
  input  logic [TIME_W-1:0] live,
  input  logic [TIME_W-1:0] low_mask,
  input  logic [TIME_W-1:0] span,
  output logic [TIME_W-1:0] result
);
  localparam int unsigned PAD_W = TIME_W - PART_W;

  logic [TIME_W-1:0] part_kept;
  logic [TIME_W-1:0] live_low;
  logic [TIME_W-1:0] joined;
  logic              wrapped;

  always_comb begin
    part_kept = {{PAD_W{1'b0}}, part} & low_mask;
    live_low  = live & low_mask;
    joined    = (live & ~low_mask) | part_kept;
    wrapped   = (live_low <= part_kept);
    result    = wrapped ? (joined - span) : joined;
  end
endmodule

// File: rtl/tstamp_out_stage.sv
module tstamp_out_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign up_ready = !full_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (take) begin
      data_q <= up_data;
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/tstamp_extend.sv
module tstamp_extend
  import tstamp_extend_pkg::*;
#(
  parameter int unsigned TS_W    = TIME_W,
  parameter int unsigned NARROW  = SHORT_W,
  parameter int unsigned WIDE    = LONG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wide,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [WIDE-1:0] in_part,
  input  logic [TS_W-1:0] cnt_now,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [TS_W-1:0] out_ts
);
  width_sel_t        sel;
  logic [TS_W-1:0]   rebuilt;

  tstamp_mask_gen #(
    .TIME_W (TS_W),
    .SHORT_W(NARROW),
    .LONG_W (WIDE)
  ) u_mask (
    .mode_wide(mode_wide),
    .low_mask (sel.keep_mask),
    .span     (sel.wrap_step)
  );

  tstamp_splice #(
    .TIME_W(TS_W),
    .PART_W(WIDE)
  ) u_splice (
    .part    (in_part),
    .live    (cnt_now),
    .low_mask(sel.keep_mask),
    .span    (sel.wrap_step),
    .result  (rebuilt)
  );

  tstamp_out_stage #(
    .DATA_W(TS_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (rebuilt),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (out_ts)
  );
endmodule

// File: rtl/tstamp_extend_chk.sv
module tstamp_extend_chk #(
  parameter int unsigned TS_W   = 64,
  parameter int unsigned NARROW = 24,
  parameter int unsigned WIDE   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_wide,
  input logic            in_valid,
  input logic            in_ready,
  input logic [WIDE-1:0] in_part,
  input logic [TS_W-1:0] cnt_now,
  input logic            out_valid,
  input logic            out_ready,
  input logic [TS_W-1:0] out_ts
);
  logic            seen_wide;
  logic [WIDE-1:0] seen_part;
  logic [TS_W-1:0] seen_now;
  logic [TS_W-1:0] seen_span;
  logic [TS_W-1:0] seen_low;
  logic [TS_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_wide <= 1'b0;
      seen_part <= '0;
      seen_now  <= '0;
    end else if (in_valid && in_ready) begin
      seen_wide <= mode_wide;
      seen_part <= in_part;
      seen_now  <= cnt_now;
    end
  end

  always_comb begin
    seen_span = seen_wide ? (TS_W'(1) << WIDE) : (TS_W'(1) << NARROW);
    seen_low  = seen_span - TS_W'(1);
    age       = seen_now - out_ts;
  end

  // R2 R3 R4 R5 R11: result lies strictly before the live count, at most one wrap back
  assert_age_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (age != '0) && (age <= seen_span));

  // R6: low N bits of the result equal the masked short value
  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_ts & seen_low) == ({{(TS_W-WIDE){1'b0}}, seen_part} & seen_low)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ts)));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind tstamp_extend tstamp_extend_chk #(
  .TS_W  (TS_W),
  .NARROW(NARROW),
  .WIDE  (WIDE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_wide(mode_wide),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_part  (in_part),
  .cnt_now  (cnt_now),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_ts   (out_ts)
);

// File: tb/tstamp_extend_test.sv
module tstamp_extend_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wide;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_part;
  logic [63:0] cnt_now;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_ts;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tstamp_extend uut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide),
    .in_valid(in_valid), .in_ready(in_ready), .in_part(in_part),
    .cnt_now(cnt_now), .out_valid(out_valid), .out_ready(out_ready),
    .out_ts(out_ts)
  );

  // {mode, short value, live count, expected}
  localparam int NV = 9;
  localparam logic [160:0] VEC [NV] = '{
    {1'b0, 32'h0000_0100, 64'h0000_0000_1234_5678, 64'h0000_0000_1200_0100}, // R2
    {1'b0, 32'h00FF_FF00, 64'h0000_0000_1200_0050, 64'h0000_0000_11FF_FF00}, // R3
    {1'b0, 32'h0000_1234, 64'h0000_0000_0A00_1234, 64'h0000_0000_0900_1234}, // R4
    {1'b1, 32'h7FFF_FFFF, 64'h0000_0005_8000_0000, 64'h0000_0005_7FFF_FFFF}, // R5
    {1'b1, 32'hFFFF_FFF0, 64'h0000_0005_0000_0010, 64'h0000_0004_FFFF_FFF0}, // R5
    {1'b0, 32'hAB00_0100, 64'h0000_0000_1234_5678, 64'h0000_0000_1200_0100}, // R6
    {1'b0, 32'h0000_0020, 64'h0000_0000_0000_0010, 64'hFFFF_FFFF_FF00_0020}, // R11
    {1'b1, 32'hDEAD_BEEF, 64'h0000_0002_DEAD_BEEF, 64'h0000_0001_DEAD_BEEF}, // R4
    {1'b0, 32'h00FF_FFFF, 64'h0000_0001_00FF_FFFF, 64'h0000_0000_FFFF_FFFF}  // R4
  };
  localparam string TAG [NV] = '{"R2", "R3", "R4", "R5", "R5", "R6", "R11", "R4", "R4"};

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_wide = 1'b0; in_valid = 1'b0; in_part = '0;
    cnt_now = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check64("R1", {63'd0, out_valid}, 64'd0);
    check64("R1", {63'd0, in_ready}, 64'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_wide = VEC[i][160];
      in_part   = VEC[i][159:128];
      cnt_now   = VEC[i][127:64];
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check64("R7", {63'd0, out_valid}, 64'd1);
      check64(TAG[i], out_ts, VEC[i][63:0]);
    end
    @(negedge clk);
    check64("R7", {63'd0, out_valid}, 64'd0);

    // Back-pressure: beat A held while out_ready is low
    out_ready = 1'b0;
    mode_wide = 1'b0; in_part = 32'h0000_0100; cnt_now = 64'h0000_0000_1234_5678;
    in_valid = 1'b1;
    @(negedge clk);
    check64("R7", {63'd0, out_valid}, 64'd1);
    check64("R8", {63'd0, in_ready}, 64'd0);
    check64("R8", out_ts, 64'h0000_0000_1200_0100);
    // beat B offered during the stall, mode flipped
    mode_wide = 1'b1; in_part = 32'h7FFF_FFFF; cnt_now = 64'h0000_0005_8000_0000;
    @(negedge clk);
    check64("R8", {63'd0, out_valid}, 64'd1);
    check64("R10", out_ts, 64'h0000_0000_1200_0100);
    check64("R8", {63'd0, in_ready}, 64'd0);
    out_ready = 1'b1;
    #0;
    check64("R9", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check64("R9", {63'd0, out_valid}, 64'd1);
    check64("R9", out_ts, 64'h0000_0005_7FFF_FFFF);
    @(negedge clk);
    check64("R7", {63'd0, out_valid}, 64'd0);

    // Reset clears a held result
    out_ready = 1'b0; mode_wide = 1'b0; in_part = 32'h1; cnt_now = 64'h5; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check64("R1", {63'd0, out_valid}, 64'd0);
    check64("R1", {63'd0, in_ready}, 64'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule